// File: doc/BRIEF.md
# Paged Address Translation Cache with Access Checks

This block caches eight translations from virtual page to physical frame for a paging scheme with two levels of 1024 entries each. A 32-bit virtual address splits into a 20-bit virtual page number (two 10-bit indexes) and a 12-bit byte offset within a 4 KiB page. A lookup is combinational. In the cycle it is presented, the block reports one of three results. A hit gives a physical address. A miss means the page is not cached and a walker elsewhere must fetch the entry. A fault means the page is cached but the access breaks its permission bits; the fault carries exception vector 5. The flag bits that the block decodes in each cached 32-bit entry are: bit 0 present, bit 1 writable, bit 2 user-accessible and bit 5 accessed. Bits 8 and up hold the frame field, and its low 20 bits form the physical page.

Refills write one entry for a given virtual page. If the page is already cached, the refill overwrites that slot in place. Otherwise it takes the slot named by a round-robin victim pointer, which then moves on. An invalidate command drops the slot that holds one virtual page. Each slot is a small state machine with three states. SLOT_EMPTY holds nothing. SLOT_LOADED holds a translation whose accessed bit is clear. SLOT_TOUCHED holds a translation whose accessed bit is set. The transitions are:
- load: from any state to LOADED or TOUCHED, following bit 5 of the written entry.
- touch: from LOADED to TOUCHED, on a clean hit.
- drop: from LOADED or TOUCHED to EMPTY, on a matching invalidate.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every slot is SLOT_EMPTY, so any valid lookup reports miss with hit, fault, lk_vector, lk_paddr and lk_entry all zero.
- R2: On a valid lookup that hits a cached page and passes every check, lk_hit is 1 in the same cycle, and lk_paddr is entry bits 27:8 followed by virtual address bits 11:0.
- R3: A valid lookup whose upper 20 virtual address bits match no cached page reports lk_miss=1, lk_hit=0, lk_fault=0 and lk_paddr=0.
- R4: A hit on an entry with bit 0 (present) clear gives lk_fault=1, lk_vector=5 and lk_paddr=0.
- R5: A write lookup (lk_write=1) that hits an entry with bit 1 (writable) clear faults. A read of the same entry does not fault.
- R6: A user lookup (lk_user=1) that hits an entry with bit 2 (user) clear faults. A supervisor access to the same entry does not fault.
- R7: On a hit, lk_entry shows the cached entry with bit 5 as the accessed bit. A hit that does not fault sets that bit, and the change shows from the next cycle. A faulting hit leaves the bit unchanged.
- R8: A refill of an uncached page fills slots in round-robin order. The ninth distinct page evicts the first page loaded.
- R9: A refill of a page that is already cached replaces that slot's entry. It does not advance the victim pointer or create a second copy.
- R10: An invalidate removes the matching page, so later lookups miss. An invalidate of an uncached page changes nothing.
- R11: When an invalidate and a refill arrive in the same cycle, the invalidate is performed and the refill is discarded.
- R12: With lk_valid=0, lk_hit, lk_miss, lk_fault, lk_vector, lk_paddr and lk_entry are all zero, and no accessed bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup comes from user mode |
| lk_hit | output | 1 | Page found in the cache |
| lk_miss | output | 1 | Page not cached |
| lk_fault | output | 1 | Page cached but access not permitted |
| lk_vector | output | 8 | Exception vector on fault (5), else 0 |
| lk_paddr | output | 32 | Physical address on a clean hit, else 0 |
| lk_entry | output | 32 | Cached entry on a hit, bit 5 = accessed state |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page number being refilled |
| fill_pte | input | 32 | Entry to cache |
| inval_valid | input | 1 | Invalidate request |
| inval_vpn | input | 20 | Virtual page number to invalidate |

## Verification
The bench probes permissions one rule at a time on entries that fail exactly one rule. A design that mixes up the writable and user bits therefore shows up as a fault on the wrong access kind. It also looks up an address whose low page bits alias a cached page but whose high bits differ. A tag compare that drops upper bits would report a false hit there. It checks the accessed bit after clean hits, after faulting hits and after idle cycles with an address present. A design that touches on faults or on idle requests would show bit 5 set where it should be clear. Eviction order is checked after an in-place refill and after a refill that was discarded alongside an invalidate. A pointer that advanced in either case would evict a different page than expected.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Flag positions decoded inside a cached entry
    localparam int FLAG_PRESENT  = 0;
    localparam int FLAG_WRITABLE = 1;
    localparam int FLAG_USER     = 2;
    localparam int FLAG_ACCESSED = 5;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_LOADED  = 2'd1,
        SLOT_TOUCHED = 2'd2
    } slot_state_e;

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
    import tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PTE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             ld_en,
    input  logic [VPN_W-1:0] ld_vpn,
    input  logic [PTE_W-1:0] ld_pte,
    input  logic             touch,
    output logic             lk_match,
    output logic             ld_match,
    output logic             inv_match,
    output logic [PTE_W-1:0] pte_out
);

    slot_state_e      state_q, state_d;
    logic [VPN_W-1:0] tag_q;
    logic [PTE_W-1:0] pte_q;
    logic             live;
    slot_state_e      load_state;

    assign load_state = ld_pte[FLAG_ACCESSED] ? SLOT_TOUCHED : SLOT_LOADED;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (ld_en) state_d = load_state;
            end
            SLOT_LOADED: begin
                if (inv_en && inv_match) state_d = SLOT_EMPTY;
                else if (ld_en)          state_d = load_state;
                else if (touch)          state_d = SLOT_TOUCHED;
            end
            SLOT_TOUCHED: begin
                if (inv_en && inv_match) state_d = SLOT_EMPTY;
                else if (ld_en)          state_d = load_state;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // Payload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            pte_q <= '0;
        end else if (ld_en) begin
            tag_q <= ld_vpn;
            pte_q <= ld_pte;
        end
    end

    // Outputs
    always_comb begin
        live      = (state_q != SLOT_EMPTY);
        lk_match  = live && (tag_q == lk_vpn);
        ld_match  = live && (tag_q == ld_vpn);
        inv_match = live && (tag_q == inv_vpn);
        pte_out   = pte_q;
        pte_out[FLAG_ACCESSED] = (state_q == SLOT_TOUCHED);
    end

    a_r10_drop_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_match) |=> (state_q == SLOT_EMPTY));

    a_r7_touch_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (touch && !ld_en && !(inv_en && inv_match)) |=> (state_q == SLOT_TOUCHED));

    a_r9_load_holds_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !inv_en) |=> (ld_match || (tag_q == $past(ld_vpn))));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    output logic [ENTRIES-1:0] victim_oh
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            ptr_q <= '0;
        else if (advance)      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_dec
        assign victim_oh[i] = (ptr_q == IDX_W'(i));
    end

    a_r8_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(victim_oh));

    a_r8_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));

    a_r9_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q));

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm #(
    parameter int PAGE_BITS = 12,
    parameter int FRAME_W   = 20,
    parameter int VEC_W     = 8,
    parameter int FAULT_VEC = 5
) (
    input  logic                 hit,
    input  logic                 acc_write,
    input  logic                 acc_user,
    input  logic                 f_present,
    input  logic                 f_writable,
    input  logic                 f_user,
    input  logic [FRAME_W-1:0]   frame,
    input  logic [PAGE_BITS-1:0] offset,
    output logic                 fault,
    output logic [VEC_W-1:0]     vector,
    output logic [FRAME_W+PAGE_BITS-1:0] paddr
);

    logic bad_present, bad_write, bad_user;

    always_comb begin
        bad_present = !f_present;
        bad_write   = acc_write && !f_writable;
        bad_user    = acc_user && !f_user;
        fault       = hit && (bad_present || bad_write || bad_user);
        vector      = fault ? VEC_W'(FAULT_VEC) : '0;
        paddr       = (hit && !fault) ? {frame, offset} : '0;
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PTE_W     = 32,
    parameter int FRAME_LSB = 8,
    parameter int ENTRIES   = 8,
    parameter int VEC_W     = 8,
    parameter int FAULT_VEC = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      lk_valid,
    input  logic [VA_W-1:0]           lk_vaddr,
    input  logic                      lk_write,
    input  logic                      lk_user,
    output logic                      lk_hit,
    output logic                      lk_miss,
    output logic                      lk_fault,
    output logic [VEC_W-1:0]          lk_vector,
    output logic [VA_W-1:0]           lk_paddr,
    output logic [PTE_W-1:0]          lk_entry,
    input  logic                      fill_valid,
    input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
    input  logic [PTE_W-1:0]          fill_pte,
    input  logic                      inval_valid,
    input  logic [VA_W-PAGE_BITS-1:0] inval_vpn
);

    localparam int VPN_W   = VA_W - PAGE_BITS;
    localparam int FRAME_W = VA_W - PAGE_BITS;

    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] lk_match_v, ld_match_v, inv_match_v, ld_en_v, touch_v;
    logic [PTE_W-1:0]   pte_v [ENTRIES];
    logic [PTE_W-1:0]   sel_pte;
    logic [ENTRIES-1:0] victim_oh;
    logic               any_hit, fill_go, fill_new, perm_fault;
    logic [VEC_W-1:0]   perm_vec;
    logic [VA_W-1:0]    perm_paddr;

    assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        tlb_slot #(.VPN_W(VPN_W), .PTE_W(PTE_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_vpn   (lk_vpn),
            .inv_en   (inval_valid),
            .inv_vpn  (inval_vpn),
            .ld_en    (ld_en_v[i]),
            .ld_vpn   (fill_vpn),
            .ld_pte   (fill_pte),
            .touch    (touch_v[i]),
            .lk_match (lk_match_v[i]),
            .ld_match (ld_match_v[i]),
            .inv_match(inv_match_v[i]),
            .pte_out  (pte_v[i])
        );
    end

    // Entry select: at most one slot matches
    always_comb begin
        sel_pte = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel_pte = sel_pte | (pte_v[i] & {PTE_W{lk_match_v[i]}});
        end
    end

    assign any_hit = lk_valid && (|lk_match_v);

    tlb_perm #(
        .PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W),
        .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)
    ) u_perm (
        .hit       (any_hit),
        .acc_write (lk_write),
        .acc_user  (lk_user),
        .f_present (sel_pte[FLAG_PRESENT]),
        .f_writable(sel_pte[FLAG_WRITABLE]),
        .f_user    (sel_pte[FLAG_USER]),
        .frame     (sel_pte[FRAME_LSB +: FRAME_W]),
        .offset    (lk_vaddr[PAGE_BITS-1:0]),
        .fault     (perm_fault),
        .vector    (perm_vec),
        .paddr     (perm_paddr)
    );

    // Refill routing: in place on a cached page, else the round-robin victim
    assign fill_go  = fill_valid && !inval_valid;
    assign fill_new = fill_go && !(|ld_match_v);

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ld_en_v[i] = fill_go && ((|ld_match_v) ? ld_match_v[i] : victim_oh[i]);
            touch_v[i] = any_hit && !perm_fault && lk_match_v[i];
        end
    end

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (fill_new),
        .victim_oh(victim_oh)
    );

    always_comb begin
        lk_hit    = any_hit;
        lk_miss   = lk_valid && !(|lk_match_v);
        lk_fault  = perm_fault;
        lk_vector = perm_vec;
        lk_paddr  = perm_paddr;
        lk_entry  = any_hit ? sel_pte : '0;
    end

    a_r3_one_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match_v));

    a_r4_fault_vector: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_hit && lk_vector == VEC_W'(FAULT_VEC) && lk_paddr == '0));

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !lk_fault) |-> (lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss && !lk_fault && lk_entry == '0));

    a_r11_inval_wins: assert property (@(posedge clk) disable iff (!rst_n)
        inval_valid |-> (ld_en_v == '0));

endmodule

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [7:0]  lk_vector;
    logic [31:0] lk_paddr, lk_entry;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [31:0] fill_pte = '0;
    logic        inval_valid = 1'b0;
    logic [19:0] inval_vpn = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tlb_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_vector(lk_vector), .lk_paddr(lk_paddr), .lk_entry(lk_entry),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
        .inval_valid(inval_valid), .inval_vpn(inval_vpn)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic [1:0]  kind;   // 0 miss, 1 hit, 2 fault
        logic [3:0]  req;
        logic [31:0] pa;
    } row_t;

    localparam row_t ROWS [12] = '{
        '{32'h0000_1123, 1'b0, 1'b0, 2'd1, 4'd2, 32'hABCD_E123},
        '{32'h0000_1FFF, 1'b1, 1'b1, 2'd1, 4'd2, 32'hABCD_EFFF},
        '{32'h0000_2004, 1'b0, 1'b0, 2'd1, 4'd2, 32'h1234_5004},
        '{32'h0000_2004, 1'b1, 1'b0, 2'd2, 4'd5, 32'h0},
        '{32'h0000_2004, 1'b0, 1'b1, 2'd2, 4'd6, 32'h0},
        '{32'h0000_3000, 1'b0, 1'b0, 2'd2, 4'd4, 32'h0},
        '{32'h0000_4010, 1'b0, 1'b1, 2'd1, 4'd2, 32'h0F0F_0010},
        '{32'h0000_4010, 1'b1, 1'b1, 2'd2, 4'd5, 32'h0},
        '{32'h0000_5ABC, 1'b1, 1'b0, 2'd1, 4'd2, 32'hFFFF_FABC},
        '{32'h0000_5ABC, 1'b0, 1'b1, 2'd2, 4'd6, 32'h0},
        '{32'h0000_9000, 1'b0, 1'b0, 2'd0, 4'd3, 32'h0},
        '{32'h8000_1123, 1'b0, 1'b0, 2'd0, 4'd3, 32'h0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd2:    return "R2 clean hit";
            4'd3:    return "R3 miss";
            4'd4:    return "R4 not present";
            4'd5:    return "R5 write protect";
            default: return "R6 user protect";
        endcase
    endfunction

    function automatic logic [63:0] result();
        return {21'd0, lk_hit, lk_miss, lk_fault, lk_vector, lk_paddr};
    endfunction

    function automatic logic [63:0] expect_of(input logic [1:0] kind, input logic [31:0] pa);
        case (kind)
            2'd0:    return {21'd0, 1'b0, 1'b1, 1'b0, 8'd0, 32'd0};
            2'd1:    return {21'd0, 1'b1, 1'b0, 1'b0, 8'd0, pa};
            default: return {21'd0, 1'b1, 1'b0, 1'b1, 8'd5, 32'd0};
        endcase
    endfunction

    // All tasks start and end at a falling edge
    task automatic fill(input logic [19:0] vpn, input logic [31:0] pte);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pte = pte;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic inval(input logic [19:0] vpn);
        inval_valid = 1'b1; inval_vpn = vpn;
        @(negedge clk);
        inval_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic wr, input logic usr);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_user = usr;
        #1;
    endtask

    task automatic look_end();
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0; lk_user = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty after reset
        look(32'h0000_1123, 1'b0, 1'b0);
        chk("R1 reset lookup", result(), expect_of(2'd0, 32'd0));
        chk("R1 reset entry", {32'd0, lk_entry}, 64'd0);
        look_end();

        fill(20'h00001, {4'hF, 20'hABCDE, 8'h07});
        fill(20'h00002, {4'hF, 20'h12345, 8'h01});
        fill(20'h00003, {4'hF, 20'h55555, 8'h00});
        fill(20'h00004, {4'hF, 20'h0F0F0, 8'h05});
        fill(20'h00005, {4'hF, 20'hFFFFF, 8'h03});

        for (int i = 0; i < 12; i++) begin
            look(ROWS[i].va, ROWS[i].wr, ROWS[i].usr);
            chk(req_name(ROWS[i].req), result(), expect_of(ROWS[i].kind, ROWS[i].pa));
            look_end();
        end

        // R7: accessed bit after clean hits, unchanged after faults
        look(32'h0000_1000, 1'b0, 1'b0);
        chk("R7 accessed set page1", {32'd0, lk_entry}, {32'd0, 4'hF, 20'hABCDE, 8'h27});
        look_end();
        look(32'h0000_3000, 1'b0, 1'b0);
        chk("R7 faulting page untouched", {56'd0, lk_entry[7:0]}, 64'h00);
        look_end();
        look(32'h0000_4000, 1'b0, 1'b1);
        chk("R7 accessed set page4", {56'd0, lk_entry[7:0]}, 64'h25);
        look_end();

        // R12: idle request is quiet and does not touch
        fill(20'h00006, {4'h0, 20'h66666, 8'h07});
        lk_valid = 1'b0; lk_vaddr = 32'h0000_6000;
        #1;
        chk("R12 idle outputs", {result()[42:0], 21'd0} | {32'd0, lk_entry}, 64'd0);
        @(negedge clk);
        look(32'h0000_6000, 1'b0, 1'b0);
        chk("R12 no touch while idle", {56'd0, lk_entry[7:0]}, 64'h07);
        look_end();

        // R9: refill of a cached page in place
        fill(20'h00002, {4'h0, 20'h22222, 8'h07});
        look(32'h0000_2abc, 1'b1, 1'b1);
        chk("R9 refill replaces", result(), expect_of(2'd1, 32'h2222_2abc));
        look_end();

        // R10: invalidate present and absent pages
        inval(20'h00003);
        look(32'h0000_3000, 1'b0, 1'b0);
        chk("R10 invalidated misses", result(), expect_of(2'd0, 32'd0));
        look_end();
        inval(20'h00077);
        look(32'h0000_5004, 1'b0, 1'b0);
        chk("R10 absent invalidate no effect", result(), expect_of(2'd1, 32'hFFFF_F004));
        look_end();

        // R11: simultaneous invalidate and refill
        fill_valid = 1'b1; fill_vpn = 20'h00007; fill_pte = {4'h0, 20'h77777, 8'h07};
        inval_valid = 1'b1; inval_vpn = 20'h00004;
        @(negedge clk);
        fill_valid = 1'b0; inval_valid = 1'b0;
        look(32'h0000_4000, 1'b0, 1'b0);
        chk("R11 invalidate done", result(), expect_of(2'd0, 32'd0));
        look_end();
        look(32'h0000_7000, 1'b0, 1'b0);
        chk("R11 refill dropped", result(), expect_of(2'd0, 32'd0));
        look_end();

        // R8: round-robin eviction (pointer at slot 6 here)
        fill(20'h00010, {4'h0, 20'h10010, 8'h07});
        fill(20'h00011, {4'h0, 20'h10011, 8'h07});
        fill(20'h00012, {4'h0, 20'h10012, 8'h07});
        look(32'h0000_1000, 1'b0, 1'b0);
        chk("R8 oldest evicted", result(), expect_of(2'd0, 32'd0));
        look_end();
        look(32'h0001_2345, 1'b0, 1'b0);
        chk("R8 newest present", result(), expect_of(2'd1, 32'h1001_2345));
        look_end();
        look(32'h0001_0001, 1'b0, 1'b0);
        chk("R8 slot six kept", result(), expect_of(2'd1, 32'h1001_0001));
        look_end();
        look(32'h0000_2000, 1'b0, 1'b0);
        chk("R8 slot one kept", result(), expect_of(2'd1, 32'h2222_2000));
        look_end();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule